// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of an 8-bit successive-approximation analog-to-digital converter. It places a trial code on an external DAC and reads back one comparator bit per decision. From that bit it settles the result with a binary search, one bit per clock, from the most significant bit down to the least. The analog parts sit outside the block: the sample-and-hold, the DAC and the comparator.

The datapath has 2N flip-flops. A one-hot pointer register of N flops marks the bit under test. A trial register of N flops holds the bits already decided, with the bit under test forced high. The trial register drives the DAC directly, so the DAC code is registered and holds steady for a whole cycle.

Every conversion takes a fixed 10-clock frame. The frame has one sample/clear cycle, eight decision cycles and one publish cycle, so the clock must run at ten times the sample rate. A controller state machine sequences the frame. Its states are:
- `ST_IDLE`: waiting for a conversion.
- `ST_SAMPLE`: sample/clear.
- `ST_DECIDE`: one bit per cycle.
- `ST_PUBLISH`: hand-off of the result.

Its transitions are:
- idle→sample when `start` is high.
- sample→decide, always.
- decide→decide while the pointer is not on bit 0.
- decide→publish when the pointer is on bit 0.
- publish→sample when `start` is high, otherwise publish→idle.

Holding `start` high therefore chains frames back to back with no gap.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous active-high `rst` forces, from the next clock edge onward and even during a conversion, `dac_code`=0, `data_out`=0, `done`=0 and `sample_hold`=0, with the controller idle.
- R2: When `start` is high in the idle state, the next cycle is the single sample cycle: `sample_hold`=1 for exactly that one cycle, and `dac_code`=0 (all trial bits cleared).
- R3: In the eight decision cycles after the sample cycle, `dac_code` in decision cycle k (k=1..8) equals the bits already decided above bit 8-k, with bit 8-k set to 1 and all lower bits 0. The first trial code is therefore 0x80.
- R4: `cmp_hi` is sampled at the clock edge that ends each decision cycle. When it is 0 (the DAC above the input), the bit under test is cleared. When it is 1, the bit stays set.
- R5: `done` is a one-cycle pulse in the cycle right after the publish cycle. That is 10 clock edges after the edge that accepted `start`. In that cycle `data_out` holds the final 8-bit code, and it keeps that value until the next `done` or reset.
- R6: With an ideal comparator `cmp_hi = (vin >= dac_code)`, every input 0..255 converts to `data_out` equal to `vin`.
- R7: `start` is ignored while a conversion is in progress. It causes no extra sample cycle and no extra `done`, and it does not change the frame length.
- R8: While `start` stays high, consecutive conversions follow with a 10-cycle period. The next sample cycle coincides with the `done` cycle of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, 10x the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion; held high for continuous conversions |
| cmp_hi | input | 1 | Comparator result, 1 when the input is at or above the DAC level |
| sample_hold | output | 1 | High during the sample cycle, drives the track/hold switch |
| dac_code | output | 8 | Registered trial code to the DAC |
| data_out | output | 8 | Last completed conversion result |
| done | output | 1 | One-cycle pulse marking a new `data_out` |

## Verification
A corrupted pointer or trial register appears at the DAC port within one cycle: a trial code that does not match the binary-search sequence, or a bit that fails to clear when the comparator is low. If the pointer loses its one-hot marker, the decide state never reaches the last bit, so `done` arrives late or never. The exact cycle of `done` is therefore checked on every conversion. A state machine that leaks out of the idle state, or that accepts `start` mid-frame, shows up as an unexpected `sample_hold` pulse or an unrequested `done` within the same frame.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_DECIDE  = 2'd2,
        ST_PUBLISH = 2'd3
    } sar_state_e;

    // Overhead cycles in each frame: one sample/clear, one publish.
    localparam int unsigned OVERHEAD_CYCLES = 2;

endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic last_bit,
    output logic clear_trial,
    output logic seed,
    output logic decide,
    output logic publish,
    output logic sample_hold
);

    sar_state_e state_q;
    sar_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = start ? ST_SAMPLE : ST_IDLE;
            ST_SAMPLE:  state_d = ST_DECIDE;
            ST_DECIDE:  state_d = last_bit ? ST_PUBLISH : ST_DECIDE;
            ST_PUBLISH: state_d = start ? ST_SAMPLE : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output strobes
    always_comb begin
        clear_trial = 1'b0;
        seed        = 1'b0;
        decide      = 1'b0;
        publish     = 1'b0;
        sample_hold = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clear_trial = start;
            end
            ST_SAMPLE: begin
                sample_hold = 1'b1;
                seed        = 1'b1;
            end
            ST_DECIDE: begin
                decide = 1'b1;
            end
            ST_PUBLISH: begin
                publish     = 1'b1;
                clear_trial = start;
            end
            default: begin
                clear_trial = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sar_bit_pointer.sv
module sar_bit_pointer #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed,
    input  logic         decide,
    output logic [N-1:0] ptr,
    output logic         last_bit
);

    logic [N-1:0] ptr_q;

    // One-hot marker: loaded on the MSB, walks one place down per decision.
    for (genvar i = 0; i < N; i++) begin : g_ptr
        if (i == N - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst) begin
                    ptr_q[i] <= 1'b0;
                end else if (seed) begin
                    ptr_q[i] <= 1'b1;
                end else if (decide) begin
                    ptr_q[i] <= 1'b0;
                end
            end
        end else begin : g_low
            always_ff @(posedge clk) begin
                if (rst) begin
                    ptr_q[i] <= 1'b0;
                end else if (seed) begin
                    ptr_q[i] <= 1'b0;
                end else if (decide) begin
                    ptr_q[i] <= ptr_q[i+1];
                end
            end
        end
    end

    assign ptr      = ptr_q;
    assign last_bit = ptr_q[0];

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_trial,
    input  logic         seed,
    input  logic         decide,
    input  logic [N-1:0] ptr,
    input  logic         cmp_hi,
    output logic [N-1:0] trial
);

    logic [N-1:0] trial_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == N - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst || clear_trial) begin
                    trial_q[i] <= 1'b0;
                end else if (seed) begin
                    trial_q[i] <= 1'b1;
                end else if (decide && ptr[i]) begin
                    trial_q[i] <= cmp_hi;
                end
            end
        end else begin : g_low
            always_ff @(posedge clk) begin
                if (rst || clear_trial) begin
                    trial_q[i] <= 1'b0;
                end else if (seed) begin
                    trial_q[i] <= 1'b0;
                end else if (decide && ptr[i]) begin
                    // Resolve the bit under test.
                    trial_q[i] <= cmp_hi;
                end else if (decide && ptr[i+1]) begin
                    // Force the next lower bit high for the coming trial.
                    trial_q[i] <= 1'b1;
                end
            end
        end
    end

    assign trial = trial_q;

endmodule

// File: rtl/sar_publish.sv
module sar_publish #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         publish,
    input  logic [N-1:0] trial,
    output logic [N-1:0] data_out,
    output logic         done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            done     <= 1'b0;
        end else begin
            done <= publish;
            if (publish) begin
                data_out <= trial;
            end
        end
    end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         cmp_hi,
    output logic         sample_hold,
    output logic [N-1:0] dac_code,
    output logic [N-1:0] data_out,
    output logic         done
);

    logic         clear_trial;
    logic         seed;
    logic         decide;
    logic         publish;
    logic         last_bit;
    logic [N-1:0] ptr;
    logic [N-1:0] trial;

    sar_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .last_bit   (last_bit),
        .clear_trial(clear_trial),
        .seed       (seed),
        .decide     (decide),
        .publish    (publish),
        .sample_hold(sample_hold)
    );

    sar_bit_pointer #(.N(N)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .seed    (seed),
        .decide  (decide),
        .ptr     (ptr),
        .last_bit(last_bit)
    );

    sar_trial_reg #(.N(N)) u_trial (
        .clk        (clk),
        .rst        (rst),
        .clear_trial(clear_trial),
        .seed       (seed),
        .decide     (decide),
        .ptr        (ptr),
        .cmp_hi     (cmp_hi),
        .trial      (trial)
    );

    sar_publish #(.N(N)) u_pub (
        .clk     (clk),
        .rst     (rst),
        .publish (publish),
        .trial   (trial),
        .data_out(data_out),
        .done    (done)
    );

    assign dac_code = trial;

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         sample_hold,
    input logic [N-1:0] dac_code,
    input logic [N-1:0] data_out,
    input logic         done
);

    localparam int unsigned FRAME = N + sar_ctrl_pkg::OVERHEAD_CYCLES;
    localparam int unsigned CW    = $clog2(FRAME + 1) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] gap_q;
    logic          seen_q;

    // Cycles elapsed since the last sample cycle, saturating.
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (sample_hold) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != CMAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2
    sample_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sample_hold |=> !sample_hold);

    // R2
    sample_clears_chk: assert property (@(posedge clk) disable iff (rst)
        sample_hold |-> (dac_code == '0));

    // R3
    first_trial_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_hold) |-> (dac_code == {1'b1, {(N-1){1'b0}}}));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_data_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (data_out == $past(dac_code)));

    // R5
    done_timing_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (seen_q && gap_q == CW'(FRAME - 1)));

    // R7
    frame_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_hold && seen_q) |-> (gap_q >= CW'(FRAME - 1)));

endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_hold(sample_hold),
    .dac_code   (dac_code),
    .data_out   (data_out),
    .done       (done)
);

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] vin = 8'd0;
    logic       cmp_hi;
    logic       sample_hold;
    logic [7:0] dac_code;
    logic [7:0] data_out;
    logic       done;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int exp_val_q[$];
    int exp_due_q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // Ideal comparator model.
    assign cmp_hi = (vin >= dac_code);

    sar_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmp_hi     (cmp_hi),
        .sample_hold(sample_hold),
        .dac_code   (dac_code),
        .data_out   (data_out),
        .done       (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_val_q.size() == 0) begin
                chk(1'b0, "R7 unrequested done", 1, 0);
            end else begin
                int ev;
                int ed;
                ev = exp_val_q.pop_front();
                ed = exp_due_q.pop_front();
                chk(data_out == 8'(ev), "R6 conversion result", data_out, ev);
                chk(cyc == ed, "R5/R8 done cycle", cyc, ed);
            end
        end
    end

    // Begin a conversion from idle; returns at the negedge in the sample cycle.
    task automatic start_conv(input int v);
        @(negedge clk);
        vin   = 8'(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        exp_val_q.push_back(v);
        exp_due_q.push_back(cyc + 10);
    endtask

    task automatic wait_drain();
        while (exp_val_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Full trial-sequence trace of one conversion.
    task automatic trace_conv(input int v);
        logic [7:0] decided;
        logic [7:0] tr;
        start_conv(v);
        chk(sample_hold == 1'b1, "R2 sample_hold in sample cycle", sample_hold, 1);
        chk(dac_code == 8'h00, "R2 trial cleared", dac_code, 0);
        decided = 8'h00;
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk);
            tr = decided | (8'h01 << b);
            chk(dac_code == tr, "R3 trial code", dac_code, tr);
            chk(sample_hold == 1'b0, "R2 sample_hold low in decision", sample_hold, 0);
            if (8'(v) >= tr) decided = tr;   // R4 keep on high, clear on low
        end
        wait_drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int base;
        int vals[5];
        int sh_cnt;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(dac_code == 0, "R1 reset dac_code", dac_code, 0);
        chk(data_out == 0, "R1 reset data_out", data_out, 0);
        chk(done == 0, "R1 reset done", done, 0);
        chk(sample_hold == 0, "R1 reset sample_hold", sample_hold, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(sample_hold == 0, "R1 idle without start", sample_hold, 0);

        // R3/R4 detailed traces
        trace_conv(8'h5A);
        trace_conv(8'hA5);
        trace_conv(8'h00);
        trace_conv(8'hFF);
        trace_conv(8'h80);
        trace_conv(8'h7F);

        // R6 exhaustive sweep
        for (int v = 0; v < 256; v++) begin
            start_conv(v);
            wait_drain();
        end

        // R5 data_out holds after done while idle
        repeat (5) @(negedge clk);
        chk(data_out == 8'hFF, "R5 data_out held", data_out, 255);

        // R7 start pulsed mid-frame is ignored
        start_conv(8'h3C);
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sh_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (sample_hold) sh_cnt++;
        end
        chk(sh_cnt == 0, "R7 no extra sample cycle", sh_cnt, 0);
        chk(exp_val_q.size() == 0, "R7 frame completed once", exp_val_q.size(), 0);

        // R8 back-to-back frames with start held
        vals = '{8'h11, 8'hEE, 8'h01, 8'hFE, 8'h96};
        @(negedge clk);
        vin   = 8'(vals[0]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        base = cyc;
        exp_val_q.push_back(vals[0]);
        exp_due_q.push_back(base + 10);
        for (int k = 1; k < 5; k++) begin
            repeat (10) @(negedge clk);
            chk(sample_hold == 1'b1, "R8 next sample follows at once", sample_hold, 1);
            vin = 8'(vals[k]);
            exp_val_q.push_back(vals[k]);
            exp_due_q.push_back(base + 10 * k + 10);
            if (k == 4) start = 1'b0;
        end
        wait_drain();

        // R1 reset in the middle of a conversion
        start_conv(8'hAA);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        exp_val_q.delete();
        exp_due_q.delete();
        chk(dac_code == 0, "R1 mid-frame reset dac_code", dac_code, 0);
        chk(data_out == 0, "R1 mid-frame reset data_out", data_out, 0);
        chk(done == 0, "R1 mid-frame reset done", done, 0);
        chk(sample_hold == 0, "R1 mid-frame reset sample_hold", sample_hold, 0);
        rst = 1'b0;
        repeat (12) @(negedge clk);
        chk(done == 0 && sample_hold == 0, "R1 idle after reset", done, 0);

        // Recovery conversion after reset
        start_conv(8'h42);
        wait_drain();

        finish_run();
    end

endmodule